// File: doc/BRIEF.md
# Window Watchdog with Reset Generator

This block supervises a host processor by combining a reset generator with a window watchdog. After power-on, or once the supply comes back from undervoltage, it holds an active-low reset output for a long interval. It then releases reset and allows a lead interval in which the processor must give its first rising edge on the trigger input.

Once that first trigger is accepted, the block repeats a fixed pattern: a closed window, then an open window. A rising edge inside the open window restarts the pattern. A rising edge inside the closed window is a failure. So is an open window that ends with no edge. Either failure gives a short reset pulse, and the block then waits for a new first trigger.

All timing is counted in pulses of a single-cycle tick input that comes from a slow oscillator. Every duration is a parameter given in ticks. A sleep input parks the watchdog, and reset stays released while it is parked.

Top module: `wdog_rstgen`

## Requirements
- R1: While `por_n` is low, `rst_n_o` is low and `synced_o` is low.
- R2: After power-on, `rst_n_o` stays low for exactly T_RES_LONG ticks and goes high on the clock of the T_RES_LONG-th tick.
- R3: If no rising trigger edge arrives within T_LEAD ticks of reset release, `rst_n_o` goes low again for T_RES_LONG ticks, and then the lead wait repeats.
- R4: The first rising trigger edge during the lead wait sets `synced_o` and starts the closed window, with `rst_n_o` kept high.
- R5: The closed window lasts T_CLOSE ticks and the open window lasts T_OPEN ticks. A rising edge at any point in the open window, including its first and last tick, restarts the closed window without any reset.
- R6: A rising edge during the closed window, or an open window that expires with no edge, drives `rst_n_o` low for exactly T_RES_SHORT ticks. After that the block returns to the lead wait.
- R7: `synced_o` clears whenever the block enters any reset interval, and also when it enters sleep.
- R8: Only a rising edge counts as a trigger. A trigger held high, or a falling edge, in the closed window causes no reset.
- R9: While `supply_ok_i` is low, `rst_n_o` is low in the same cycle. When the supply returns, the full T_RES_LONG reset follows.
- R10: While `sleep_i` is high, the watchdog does not run: `rst_n_o` stays high, `synced_o` is low, and no reset fires however many ticks pass. Leaving sleep starts a T_RES_LONG reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | One-cycle pulse from the watchdog oscillator; all durations count these pulses |
| wd_i | input | 1 | Trigger from the processor; only rising edges count. It is synchronized internally |
| supply_ok_i | input | 1 | High while the supervised supply is above its threshold |
| sleep_i | input | 1 | High to park the watchdog |
| rst_n_o | output | 1 | Reset to the processor, active low |
| synced_o | output | 1 | High once a first trigger has been accepted since the last reset |

## Verification
The bench builds the block with short intervals: long reset 10 ticks, lead 12, closed 8, open 6 and short reset 3. The bench issues each tick itself. This makes every window boundary reachable in a few hundred cycles. It can then check the tick just before each boundary and the tick on it, including triggers on the first and last open tick and on the last closed tick. The short lengths also make it affordable to repeat the lead timeout and to let many ticks pass during sleep.

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int T_RES_LONG  = 5520,
  parameter int T_LEAD      = 5520,
  parameter int T_CLOSE     = 980,
  parameter int T_OPEN      = 780,
  parameter int T_RES_SHORT = 162
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick_i,
  input  logic wd_i,
  input  logic supply_ok_i,
  input  logic sleep_i,
  output logic rst_n_o,
  output logic synced_o
);

  localparam int MAX_A = (T_RES_LONG > T_LEAD) ? T_RES_LONG : T_LEAD;
  localparam int MAX_B = (T_CLOSE > T_OPEN) ? T_CLOSE : T_OPEN;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T = (MAX_C > T_RES_SHORT) ? MAX_C : T_RES_SHORT;
  localparam int CW    = $clog2(MAX_T + 1);

  typedef enum logic [2:0] {S_PRST, S_LEAD, S_CLOSE, S_OPEN, S_FRST, S_SLEEP} st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt, len_m1;
  logic wd_s1, wd_s2, wd_s3;
  logic synced;

  wire edge_w = wd_s2 & ~wd_s3;
  wire last_w = tick_i && (cnt == len_m1);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) {wd_s1, wd_s2, wd_s3} <= '0;
    else        {wd_s1, wd_s2, wd_s3} <= {wd_i, wd_s1, wd_s2};

  always_comb begin
    case (st)
      S_PRST:  len_m1 = CW'(T_RES_LONG - 1);
      S_LEAD:  len_m1 = CW'(T_LEAD - 1);
      S_CLOSE: len_m1 = CW'(T_CLOSE - 1);
      S_OPEN:  len_m1 = CW'(T_OPEN - 1);
      S_FRST:  len_m1 = CW'(T_RES_SHORT - 1);
      default: len_m1 = '0;
    endcase
  end

  always_comb begin
    nxt = st;
    if (!supply_ok_i)  nxt = S_PRST;
    else if (sleep_i)  nxt = S_SLEEP;
    else begin
      case (st)
        S_SLEEP: nxt = S_PRST;
        S_PRST:  if (last_w) nxt = S_LEAD;
        S_LEAD:  if (edge_w) nxt = S_CLOSE; else if (last_w) nxt = S_PRST;
        S_CLOSE: if (edge_w) nxt = S_FRST;  else if (last_w) nxt = S_OPEN;
        S_OPEN:  if (edge_w) nxt = S_CLOSE; else if (last_w) nxt = S_FRST;
        S_FRST:  if (last_w) nxt = S_LEAD;
        default: nxt = S_PRST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      st     <= S_PRST;
      cnt    <= '0;
      synced <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st || !supply_ok_i) cnt <= '0;
      else if (tick_i)               cnt <= cnt + 1'b1;
      if (nxt == S_PRST || nxt == S_FRST || nxt == S_SLEEP) synced <= 1'b0;
      else if (st == S_LEAD && nxt == S_CLOSE)              synced <= 1'b1;
    end

  assign rst_n_o  = supply_ok_i && !(st == S_PRST || st == S_FRST);
  assign synced_o = synced;

  AST_SYNC_CLR_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_PRST || st == S_FRST || st == S_SLEEP) |-> !synced_o); // R7

  AST_CLOSED_EDGE_FAILS: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_CLOSE && edge_w && supply_ok_i && !sleep_i) |=> (st == S_FRST && !rst_n_o)); // R6

  AST_OPEN_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_OPEN && edge_w && supply_ok_i && !sleep_i) |=> (st == S_CLOSE && cnt == '0)); // R5

  AST_UV_RESTART: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok_i |=> (st == S_PRST && cnt == '0)); // R9

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    (sleep_i && supply_ok_i) |=> (st == S_SLEEP)); // R10

  AST_FIRST_TRIG_SYNC: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_LEAD && edge_w && supply_ok_i && !sleep_i) |=> synced_o); // R4

endmodule

// File: tb/wdog_rstgen_tb.sv
module wdog_rstgen_tb;
  localparam int LONG = 10, LEAD = 12, CLOSE = 8, OPEN = 6, SHORT = 3;

  logic clk = 0, por_n = 0, tick_i = 0, wd_i = 0, supply_ok_i = 1, sleep_i = 0;
  logic rst_n_o, synced_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_rstgen #(.T_RES_LONG(LONG), .T_LEAD(LEAD), .T_CLOSE(CLOSE),
                .T_OPEN(OPEN), .T_RES_SHORT(SHORT)) u_dut (
    .clk(clk), .por_n(por_n), .tick_i(tick_i), .wd_i(wd_i),
    .supply_ok_i(supply_ok_i), .sleep_i(sleep_i),
    .rst_n_o(rst_n_o), .synced_o(synced_o));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1;
      @(negedge clk) tick_i = 0;
    end
  endtask

  task automatic trig();
    @(negedge clk) wd_i = 1;
    repeat (4) @(negedge clk);
    wd_i = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_power_on();
    por_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 rst", rst_n_o, 0);
    chk("R1 synced", synced_o, 0);
    por_n = 1;
    ticks(LONG - 1);
    chk("R2 still low", rst_n_o, 0);
    ticks(1);
    chk("R2 released", rst_n_o, 1);
  endtask

  task automatic t_lead_timeout();
    ticks(LEAD - 1);
    chk("R3 before timeout", rst_n_o, 1);
    ticks(1);
    chk("R3 timeout reset", rst_n_o, 0);
    ticks(LONG - 1);
    chk("R3 long reset", rst_n_o, 0);
    ticks(1);
    chk("R3 released again", rst_n_o, 1);
  endtask

  task automatic t_first_trigger();
    ticks(2);
    trig();
    chk("R4 synced", synced_o, 1);
    chk("R4 rst high", rst_n_o, 1);
  endtask

  task automatic t_good_cycles();
    for (int k = 0; k < 3; k++) begin
      ticks(CLOSE + 2);
      trig();
      chk("R5 mid open", rst_n_o, 1);
    end
    ticks(CLOSE);
    trig();
    chk("R5 first open tick", rst_n_o, 1);
    ticks(CLOSE + OPEN - 1);
    trig();
    chk("R5 last open tick", rst_n_o, 1);
    chk("R5 synced kept", synced_o, 1);
  endtask

  task automatic t_level_ignored();
    ticks(CLOSE + 1);
    @(negedge clk) wd_i = 1;
    repeat (4) @(negedge clk);
    ticks(3);
    chk("R8 held high", rst_n_o, 1);
    @(negedge clk) wd_i = 0;
    repeat (4) @(negedge clk);
    chk("R8 falling edge", rst_n_o, 1);
    ticks(CLOSE - 3 + 1);
    trig();
    chk("R8 open trigger ok", rst_n_o, 1);
  endtask

  task automatic t_early();
    ticks(CLOSE - 1);
    trig();
    chk("R6 early reset", rst_n_o, 0);
    chk("R7 synced cleared", synced_o, 0);
    ticks(SHORT - 1);
    chk("R6 short still low", rst_n_o, 0);
    ticks(1);
    chk("R6 short released", rst_n_o, 1);
    ticks(1);
    trig();
    chk("R4 resync", synced_o, 1);
  endtask

  task automatic t_missing();
    ticks(CLOSE + OPEN - 1);
    chk("R6 before expiry", rst_n_o, 1);
    ticks(1);
    chk("R6 missed trigger", rst_n_o, 0);
    ticks(SHORT);
    chk("R6 released", rst_n_o, 1);
    trig();
    chk("R4 resync2", synced_o, 1);
  endtask

  task automatic t_supply();
    @(negedge clk) supply_ok_i = 0;
    #1;
    chk("R9 immediate", rst_n_o, 0);
    @(negedge clk);
    chk("R7 uv synced", synced_o, 0);
    ticks(5);
    chk("R9 held", rst_n_o, 0);
    @(negedge clk) supply_ok_i = 1;
    ticks(LONG - 1);
    chk("R9 long after uv", rst_n_o, 0);
    ticks(1);
    chk("R9 released", rst_n_o, 1);
  endtask

  task automatic t_sleep();
    trig();
    chk("R4 before sleep", synced_o, 1);
    @(negedge clk) sleep_i = 1;
    repeat (2) @(negedge clk);
    chk("R10 rst high", rst_n_o, 1);
    chk("R10 synced low", synced_o, 0);
    ticks(50);
    chk("R10 no reset", rst_n_o, 1);
    @(negedge clk) sleep_i = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 wake reset", rst_n_o, 0);
    ticks(LONG);
    chk("R10 wake released", rst_n_o, 1);
  endtask

  initial begin
    t_power_on();
    t_lead_timeout();
    t_first_trigger();
    t_good_cycles();
    t_level_ignored();
    t_early();
    t_missing();
    t_supply();
    t_sleep();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule